// File: doc/BRIEF.md
# Programmable High/Low Phase Clock Divider Set

This block holds three integer clock dividers, named input, feedback and output, that run from one reference clock. Each divider is set by a control word that carries a high-phase count, a low-phase count, an odd-ratio edge flag, a bypass flag and a defer flag. Each divider drives a divided clock level, a one-cycle enable pulse at the start of every output period, and the divide ratio it is using at the moment.

Software writes control words through a simple write port. A write with the defer flag set is only staged. A write with the defer flag clear commits every staged word to all three dividers together. Each divider then takes up its new setting at the end of its current output period, so no shortened phase is ever produced. The usual sequence is to stage the input and feedback words with the defer flag set, then write the output word with it clear. The synthesized rate is the reference rate times the feedback ratio, divided by the product of the input and output ratios. That arithmetic is left to software, which reads the per-divider ratios. Two status inputs, lock and error, can be read back through the read port.

Top module: `hldiv_top`

## Requirements
- R1: A control word has low count in bits [5:0], high count in bits [11:6], edge flag in bit 12, bypass in bit 13 and defer in bit 14. The word for divider 0 (input) is written at byte address 0x0, divider 1 (feedback) at 0x4 and divider 2 (output) at 0x8. A write to 0xC changes no divider and no stored word.
- R2: A divider whose active word has bypass set reports ratio 1 whatever its counts hold, holds its divided clock high, and pulses its enable on every reference cycle.
- R3: The read data appears one cycle after the read address is presented. Addresses 0x0, 0x4 and 0x8 return the staged word with bits [31:15] read as zero. Address 0xC returns lock in bit 0 and error in bit 1.
- R4: A write with the defer bit set changes the staged word only. The ratios and divided clocks stay unchanged until a committing write arrives.
- R5: With bypass clear, the reported ratio is the high count plus the low count. The divided clock is high for the high count of cycles and then low for the low count. This holds for both even and odd ratios.
- R6: The enable pulses for exactly one cycle per output period, in the first cycle of the high phase.
- R7: A write with the defer bit clear to any of the three addresses makes all staged words, including its own, active at once. Each divider applies its new setting only at the end of its current period.
- R8: A count of 0 in a word with bypass clear acts as a count of 1.
- R9: After reset, all three stored words read 0x2000 (bypass set, defer clear), every ratio is 1, and every divided clock is high.
- R10: The edge flag is stored and read back. It does not alter the phase lengths, which come from the counts alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 32 | Write data (control word) |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Registered read data |
| lock_in | input | 1 | Lock status bit to be read back |
| err_in | input | 1 | Error status bit to be read back |
| div_clk | output | 3 | Divided clock levels, bit i for divider i |
| div_ce | output | 3 | Period-start enable pulses, bit i for divider i |
| div_ratio | output | 21 | Active ratios, 7 bits per divider, divider i at [7i+6:7i] |

## Verification
A write takes effect in the stored words at the clock edge that samples it. Read data comes one edge after the address is presented, so the bench sets the address at a falling edge and samples at the next falling edge. A committed setting reaches a divider's ratio and clock only at the end of that divider's current period. So after each commit the bench waits longer than the longest old period, then measures one full period, from a falling transition to the next rising transition and through the following fall, counting samples and enable pulses. For deferred writes the bench waits the same margin before checking that ratio and phase widths are still the old ones, so any premature change would already be visible.

// File: rtl/hldiv_pkg.sv
package hldiv_pkg;
  localparam int CNT_W     = 6;
  localparam int RATIO_W   = CNT_W + 1;
  localparam int NUM_DIV   = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int DEFER_BIT = 2 * CNT_W + 2;
  localparam int WORD_W    = 2 * CNT_W + 3;

  typedef struct packed {
    logic             defer;
    logic             bypass;
    logic             edge_f;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } ctrl_word_t;

  localparam ctrl_word_t RESET_WORD = '{defer: 1'b0, bypass: 1'b1, edge_f: 1'b0,
                                        hi: '0, lo: '0};

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction
endpackage

// File: rtl/hldiv_regfile.sv
module hldiv_regfile
  import hldiv_pkg::*;
#(
  parameter int N_DIV = NUM_DIV,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic       lock_in,
  input  logic       err_in,
  output logic [DW-1:0] rd_data,
  output ctrl_word_t active_o [N_DIV]
);
  localparam int SEL_W = AW - 2;

  logic [SEL_W-1:0] wsel, rsel;
  logic             wr_hit, commit;
  ctrl_word_t       staged [N_DIV];
  ctrl_word_t       active [N_DIV];
  ctrl_word_t       new_word;

  assign wsel     = wr_addr[AW-1:2];
  assign rsel     = rd_addr[AW-1:2];
  assign new_word = ctrl_word_t'(wr_data[WORD_W-1:0]);
  assign wr_hit   = wr_en && (int'(wsel) < N_DIV);
  assign commit   = wr_hit && !wr_data[DEFER_BIT];

  for (genvar i = 0; i < N_DIV; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        staged[i] <= RESET_WORD;
      end else if (wr_hit && (wsel == SEL_W'(i))) begin
        staged[i] <= new_word;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active[i] <= RESET_WORD;
      end else if (commit) begin
        active[i] <= (wsel == SEL_W'(i)) ? new_word : staged[i];
      end
    end

    assign active_o[i] = active[i];

    // R4: a deferred write leaves the active words alone
    assert_defer_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wr_data[DEFER_BIT]) |=> $stable(active[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rsel) < N_DIV) begin
      rd_data <= DW'(staged[rsel]);
    end else begin
      rd_data <= DW'({err_in, lock_in});
    end
  end

  // R3: reserved bits always read as zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:WORD_W] == '0);
endmodule

// File: rtl/hldiv_core.sv
module hldiv_core
  import hldiv_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int RW = RATIO_W
) (
  input  logic       clk,
  input  logic       rst,
  input  ctrl_word_t cfg,
  output logic       clk_o,
  output logic       ce_o,
  output logic [RW-1:0] ratio_o
);
  logic          cur_byp;
  logic [CW-1:0] cur_hi, cur_lo, cnt;
  logic          phase_hi, ce_q;
  logic [RW-1:0] ratio_q;
  logic [CW-1:0] hi_e, lo_e;
  logic          boundary, hi_done;

  assign hi_e     = eff_count(cfg.hi);
  assign lo_e     = eff_count(cfg.lo);
  assign boundary = cur_byp || (!phase_hi && (cnt == cur_lo - CW'(1)));
  assign hi_done  = phase_hi && (cnt == cur_hi - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_byp  <= 1'b1;
      cur_hi   <= CW'(1);
      cur_lo   <= CW'(1);
      phase_hi <= 1'b1;
      cnt      <= '0;
      ce_q     <= 1'b0;
      ratio_q  <= RW'(1);
    end else begin
      ce_q <= 1'b0;
      if (boundary) begin
        cur_byp  <= cfg.bypass;
        cur_hi   <= hi_e;
        cur_lo   <= lo_e;
        phase_hi <= 1'b1;
        cnt      <= '0;
        ce_q     <= 1'b1;
        ratio_q  <= cfg.bypass ? RW'(1) : (RW'(hi_e) + RW'(lo_e));
      end else if (hi_done) begin
        phase_hi <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign clk_o   = phase_hi;
  assign ce_o    = ce_q;
  assign ratio_o = ratio_q;

  // R5: the phase counter stays inside the current phase length
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !cur_byp |-> (cnt < (phase_hi ? cur_hi : cur_lo)));
  // R6: each rising edge of the divided clock carries the enable pulse
  assert_rise_ce_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_hi) |-> ce_q);
  // R7: the reported ratio moves only at a period start
  assert_ratio_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_q) |-> ce_q);
  // R2: a ratio of one means the divided clock is held high
  assert_bypass_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == RW'(1)) |-> phase_hi);
endmodule

// File: rtl/hldiv_top.sv
module hldiv_top
  import hldiv_pkg::*;
#(
  parameter int N_DIV = NUM_DIV,
  parameter int CW    = CNT_W,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  localparam int RW   = CW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic                lock_in,
  input  logic                err_in,
  output logic [N_DIV-1:0]    div_clk,
  output logic [N_DIV-1:0]    div_ce,
  output logic [N_DIV*RW-1:0] div_ratio
);
  ctrl_word_t active [N_DIV];

  hldiv_regfile #(.N_DIV(N_DIV), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .lock_in  (lock_in),
    .err_in   (err_in),
    .rd_data  (rd_data),
    .active_o (active)
  );

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    hldiv_core #(.CW(CW), .RW(RW)) u_core (
      .clk     (clk),
      .rst     (rst),
      .cfg     (active[i]),
      .clk_o   (div_clk[i]),
      .ce_o    (div_ce[i]),
      .ratio_o (div_ratio[i*RW +: RW])
    );
  end

  // R6: enable pulses never land on a low divided clock
  assert_ce_high_R6: assert property (@(posedge clk) disable iff (rst)
    div_ce == (div_ce & div_clk));
endmodule

// File: tb/sim_hldiv_top.sv
module sim_hldiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lock_in = 1'b0, err_in = 1'b0;
  logic [2:0]  div_clk, div_ce;
  logic [20:0] div_ratio;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hldiv_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lock_in(lock_in),
    .err_in(err_in), .div_clk(div_clk), .div_ce(div_ce), .div_ratio(div_ratio));

  // {hi, lo, expected high width, expected low width}
  localparam logic [23:0] VEC [6] = '{
    {6'd2, 6'd2, 6'd2, 6'd2}, {6'd1, 6'd2, 6'd1, 6'd2}, {6'd3, 6'd4, 6'd3, 6'd4},
    {6'd0, 6'd3, 6'd1, 6'd3}, {6'd5, 6'd5, 6'd5, 6'd5}, {6'd2, 6'd0, 6'd2, 6'd1}};

  function automatic logic [31:0] enc(int hi, int lo, bit edg, bit byp, bit dfr);
    return {17'b0, dfr, byp, edg, 6'(hi), 6'(lo)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic int ratio_of(int i);
    return int'(div_ratio[i*7 +: 7]);
  endfunction

  task automatic measure(int i, output int hw, output int lw, output int ces);
    int g = 0;
    hw = 0; lw = 0; ces = 0;
    @(negedge clk);
    while (div_clk[i] !== 1'b0 && g < 600) begin @(negedge clk); g++; end
    while (div_clk[i] !== 1'b1 && g < 600) begin @(negedge clk); g++; end
    while (div_clk[i] === 1'b1 && g < 600) begin
      hw++; if (div_ce[i]) ces++; @(negedge clk); g++;
    end
    while (div_clk[i] === 1'b0 && g < 600) begin
      lw++; if (div_ce[i]) ces++; @(negedge clk); g++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hw, lw, ces, n_ce, n_hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      chk("R9 ratio after reset", ratio_of(i), 1);
      rd(4'(4 * i), d);
      chk("R9 word after reset", int'(d), 32'h2000);
    end
    // R2: bypass pulses every cycle with clock held high
    n_ce = 0; n_hi = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); n_ce += int'(div_ce[2]); n_hi += int'(div_clk[2]);
    end
    chk("R2 bypass enable count", n_ce, 8);
    chk("R2 bypass clock high", n_hi, 8);

    // table walk: stage 0 and 1, commit with 2 (R1, R5, R6, R7, R8, R10)
    for (int v = 0; v < 6; v++) begin
      int hi, lo, ehw, elw;
      bit odd;
      {hi, lo, ehw, elw} = {26'b0, VEC[v][23:18], 26'b0, VEC[v][17:12],
                            26'b0, VEC[v][11:6], 26'b0, VEC[v][5:0]};
      odd = ((ehw + elw) % 2) == 1;
      wr(4'h0, enc(hi, lo, odd, 1'b0, 1'b1));
      wr(4'h4, enc(hi, lo, odd, 1'b0, 1'b1));
      wr(4'h8, enc(hi, lo, odd, 1'b0, 1'b0));
      repeat (30) @(negedge clk);
      for (int i = 0; i < 3; i++) chk("R7 ratio after commit", ratio_of(i), ehw + elw);
      measure(2, hw, lw, ces);
      chk("R5 high width out", hw, ehw);
      chk("R5 low width out", lw, elw);
      chk("R6 enables per period", ces, 1);
      measure(0, hw, lw, ces);
      chk(hi == 0 || lo == 0 ? "R8 high width zero count" : "R5 high width in", hw, ehw);
      chk(hi == 0 || lo == 0 ? "R8 low width zero count" : "R5 low width in", lw, elw);
      rd(4'h4, d);
      chk("R10 edge and counts read back", int'(d), int'(enc(hi, lo, odd, 1'b0, 1'b1)));
    end

    // R4: deferred write leaves divider 0 running at 2+1
    wr(4'h0, enc(0, 0, 0, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    chk("R4 ratio unchanged", ratio_of(0), 3);
    measure(0, hw, lw, ces);
    chk("R4 high width unchanged", hw, 2);
    chk("R4 low width unchanged", lw, 1);
    rd(4'h0, d);
    chk("R4 staged word visible", int'(d), 32'h6000);
    // R7: commit through the feedback address lands the input word too
    wr(4'h4, enc(3, 3, 0, 1'b0, 1'b0));
    repeat (30) @(negedge clk);
    chk("R7 input now bypass", ratio_of(0), 1);
    chk("R7 feedback now 6", ratio_of(1), 6);
    chk("R7 output unchanged", ratio_of(2), 3);

    // R1: write to 0xC ignored
    wr(4'hC, enc(4, 4, 0, 1'b0, 1'b0));
    repeat (30) @(negedge clk);
    chk("R1 0xC no ratio change", ratio_of(1), 6);
    rd(4'h8, d);
    chk("R1 0xC no word change", int'(d), int'(enc(2, 0, 1, 1'b0, 1'b0)));

    // R3: reserved bits dropped, status readback
    wr(4'h8, 32'hFFFF_8000 | enc(4, 2, 0, 1'b0, 1'b0));
    rd(4'h8, d);
    chk("R3 reserved bits zero", int'(d), int'(enc(4, 2, 0, 1'b0, 1'b0)));
    lock_in = 1'b1;
    rd(4'hC, d);
    chk("R3 status lock", int'(d), 1);
    err_in = 1'b1;
    rd(4'hC, d);
    chk("R3 status lock and error", int'(d), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule